// File: doc/BRIEF.md
# Health Verdict Action Escalator

This block sits beside the health monitors of a compute platform. Four monitors send it single-cycle event strobes: link retrain, memory correctable error, memory uncorrectable error and thermal limit. A free-running window timer splits time into windows of programmable length. For three of the sources, a counter per source counts strobes in each window and compares the count with a programmable threshold at the last cycle of the window. The fourth source, uncorrectable errors, acts on each strobe as it arrives.

The response depends on the source. A retrain rate over threshold first asks for bandwidth degrade. If the rate stays high, the retrain source climbs one tier at a time through isolate, recover and switch-to-redundant. A thermal rate over threshold asks for load degrade, and then safe state if it persists. A correctable-error trend never asks for an action tier. It raises a monitoring level, flags a maintenance request and takes an evidence snapshot. Each uncorrectable error moves at once to isolate, and then up one tier with each further error. Each source falls back to normal after a programmable number of consecutive clean windows. The commanded tier is the highest tier requested by any source. Every decision writes a timestamped evidence entry that carries the source, the reason and the resulting tier.

Evidence entries leave on a valid/ready stream through an internal queue. While `ev_valid` is high and `ev_ready` is low, the head entry holds still. The queue accepts up to four entries per cycle, one per source, in ascending source order. An entry that finds the queue full is dropped. The consumer must therefore drain the queue faster than windows close.

Top module: `health_escalator`

## Requirements
- R1: During reset and in the first cycle after reset, `act_tier` is 0, `mon_level` is 0, `maint_req` is 0 and `ev_valid` is 0.
- R2: A window closes in the cycle in which the window counter reaches `cfg_window`-1. A strobe in that last cycle counts toward the window. If a retrain or thermal source at tier normal (0) counts at least its threshold, it moves to degrade (1) and logs reason 0 (rate over). A count below the threshold changes nothing.
- R3: A retrain source at a tier above normal that is over threshold in `cfg_persist` consecutive windows moves up exactly one tier. The order is 1→2 (isolate) →3 (recover) →4 (switch-to-redundant). It logs reason 1 (persist), and its persistence count restarts.
- R4: A source at a raised state that sees `cfg_clean` consecutive clean windows returns to normal and logs reason 2 (clear) with tier 0. For the correctable source, clearing also sets `mon_level` and `maint_req` to 0.
- R5: Each window in which the correctable count reaches its threshold raises `mon_level` by one, saturating at 3. It sets `maint_req` and logs reason 3 (trend) with tier 0. `act_tier` is not affected.
- R6: Each uncorrectable strobe is logged in its own cycle with reason 4. The first strobe takes the source to isolate (2). Each further strobe steps it to 3, then 4, and it stays at 4 after that. A window counts as clean for this source only if it had no strobe.
- R7: The thermal source goes from degrade (1) directly to safe state (5) after `cfg_persist` consecutive over-threshold windows. It logs reason 1.
- R8: `act_tier` is the highest tier held by the retrain, uncorrectable and thermal sources. Entries made in the same cycle are delivered in ascending source order: 0 retrain, 1 correctable, 2 uncorrectable, 3 thermal.
- R9: The stamp of each entry is the cycle count since reset release of the cycle in which the decision was made. The first cycle after release has count 0.
- R10: While `ev_valid` is high and `ev_ready` is low, `ev_valid` and all entry fields stay unchanged. Every entry produced while the queue has room is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_retrain | input | 1 | Link retrain strobe |
| ev_ce | input | 1 | Correctable memory error strobe |
| ev_ue | input | 1 | Uncorrectable memory error strobe |
| ev_therm | input | 1 | Thermal limit strobe |
| cfg_window | input | WIN_W | Window length in cycles |
| cfg_thr_retrain | input | CNT_W | Retrain count threshold per window |
| cfg_thr_ce | input | CNT_W | Correctable count threshold per window |
| cfg_thr_therm | input | CNT_W | Thermal count threshold per window |
| cfg_persist | input | STEP_W | Consecutive over-threshold windows needed to escalate |
| cfg_clean | input | STEP_W | Consecutive clean windows needed to return to normal |
| act_tier | output | 3 | Commanded tier: 0 normal, 1 degrade, 2 isolate, 3 recover, 4 switch, 5 safe |
| mon_level | output | 2 | Monitoring level raised by correctable trends |
| maint_req | output | 1 | Maintenance request |
| ev_valid | output | 1 | Evidence entry available |
| ev_ready | input | 1 | Consumer accepts the entry |
| ev_stamp | output | TS_W | Entry timestamp |
| ev_src | output | 2 | Entry source code |
| ev_reason | output | 3 | Entry reason code |
| ev_tier | output | 3 | Tier after the decision |

## Verification
The bench builds the block with its default parameters: a 32-bit stamp, 16-bit window, 8-bit counters, 4-bit step counters and an 8-entry queue. It drives a window of 16, a persistence of 2 and a clean count of 3. With these values the retrain source can climb to recover, and the thermal source can reach safe state, within a few hundred cycles. A single window can also collect three simultaneous entries while the consumer stalls, which is within the queue's depth. Strobes placed in the last cycle of a window and a window one event below threshold exercise the counting boundary.

// File: rtl/hv_pkg.sv
package hv_pkg;
  typedef enum logic [2:0] {
    T_NORMAL  = 3'd0,
    T_DEGRADE = 3'd1,
    T_ISOLATE = 3'd2,
    T_RECOVER = 3'd3,
    T_SWITCH  = 3'd4,
    T_SAFE    = 3'd5
  } tier_e;

  typedef enum logic [1:0] {
    S_RETRAIN = 2'd0,
    S_CE      = 2'd1,
    S_UE      = 2'd2,
    S_THERM   = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    R_RATE_OVER = 3'd0,
    R_PERSIST   = 3'd1,
    R_CLEAR     = 3'd2,
    R_CE_TREND  = 3'd3,
    R_UE_EVENT  = 3'd4
  } reason_e;

  typedef struct packed {
    src_e    src;
    reason_e reason;
    tier_e   tier;
  } hv_tag_t;

  localparam int unsigned TAG_W = $bits(hv_tag_t);

  function automatic tier_e tier_max(tier_e a, tier_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hv_rate_engine.sv
module hv_rate_engine
  import hv_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned STEP_W  = 4,
  parameter bit          THERMAL = 1'b0,
  parameter src_e        SRC     = S_RETRAIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              wnd_end,
  input  logic [CNT_W-1:0]  thr,
  input  logic [STEP_W-1:0] persist_n,
  input  logic [STEP_W-1:0] clean_m,
  output tier_e             tier,
  output logic              log_req,
  output hv_tag_t           log_tag
);
  localparam tier_e TOP_TIER = THERMAL ? T_SAFE : T_SWITCH;

  function automatic tier_e step_up(tier_e t);
    tier_e n;
    if (THERMAL) begin
      n = (t == T_NORMAL) ? T_DEGRADE : T_SAFE;
    end else begin
      case (t)
        T_NORMAL:  n = T_DEGRADE;
        T_DEGRADE: n = T_ISOLATE;
        T_ISOLATE: n = T_RECOVER;
        default:   n = T_SWITCH;
      endcase
    end
    return n;
  endfunction

  logic [CNT_W-1:0]  cnt_q, eval;
  logic [STEP_W-1:0] pc_q, pc_d, cc_q, cc_d;
  tier_e             tier_d;
  logic              over, pc_hit, cc_hit;

  assign eval   = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(strobe);
  assign over   = eval >= thr;
  assign pc_hit = ((STEP_W+1)'(pc_q) + (STEP_W+1)'(1)) >= (STEP_W+1)'(persist_n);
  assign cc_hit = ((STEP_W+1)'(cc_q) + (STEP_W+1)'(1)) >= (STEP_W+1)'(clean_m);

  always_comb begin
    tier_d  = tier;
    pc_d    = pc_q;
    cc_d    = cc_q;
    log_req = 1'b0;
    log_tag = '{src: SRC, reason: R_RATE_OVER, tier: T_NORMAL};
    if (wnd_end) begin
      if (over) begin
        cc_d = '0;
        if (tier == T_NORMAL) begin
          tier_d  = T_DEGRADE;
          pc_d    = '0;
          log_req = 1'b1;
          log_tag = '{src: SRC, reason: R_RATE_OVER, tier: T_DEGRADE};
        end else if (tier != TOP_TIER) begin
          if (pc_hit) begin
            tier_d  = step_up(tier);
            pc_d    = '0;
            log_req = 1'b1;
            log_tag = '{src: SRC, reason: R_PERSIST, tier: step_up(tier)};
          end else begin
            pc_d = pc_q + STEP_W'(1);
          end
        end
      end else begin
        pc_d = '0;
        if (tier != T_NORMAL) begin
          if (cc_hit) begin
            tier_d  = T_NORMAL;
            cc_d    = '0;
            log_req = 1'b1;
            log_tag = '{src: SRC, reason: R_CLEAR, tier: T_NORMAL};
          end else begin
            cc_d = cc_q + STEP_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pc_q  <= '0;
      cc_q  <= '0;
      tier  <= T_NORMAL;
    end else begin
      cnt_q <= wnd_end ? '0 : eval;
      pc_q  <= pc_d;
      cc_q  <= cc_d;
      tier  <= tier_d;
    end
  end

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tier != $past(tier) && tier != T_NORMAL) |-> (tier == step_up($past(tier))));
endmodule

// File: rtl/hv_ce_trend.sv
module hv_ce_trend
  import hv_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              wnd_end,
  input  logic [CNT_W-1:0]  thr,
  input  logic [STEP_W-1:0] clean_m,
  output logic [1:0]        mon_level,
  output logic              maint_req,
  output logic              log_req,
  output hv_tag_t           log_tag
);
  logic [CNT_W-1:0]  cnt_q, eval;
  logic [STEP_W-1:0] cc_q;
  logic              over, cc_hit;

  assign eval   = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(strobe);
  assign over   = eval >= thr;
  assign cc_hit = ((STEP_W+1)'(cc_q) + (STEP_W+1)'(1)) >= (STEP_W+1)'(clean_m);

  always_comb begin
    log_req = 1'b0;
    log_tag = '{src: S_CE, reason: R_CE_TREND, tier: T_NORMAL};
    if (wnd_end) begin
      if (over) begin
        log_req = 1'b1;
      end else if (maint_req && cc_hit) begin
        log_req = 1'b1;
        log_tag = '{src: S_CE, reason: R_CLEAR, tier: T_NORMAL};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cc_q      <= '0;
      mon_level <= '0;
      maint_req <= 1'b0;
    end else begin
      cnt_q <= wnd_end ? '0 : eval;
      if (wnd_end) begin
        if (over) begin
          cc_q      <= '0;
          maint_req <= 1'b1;
          mon_level <= (&mon_level) ? mon_level : mon_level + 2'd1;
        end else if (maint_req) begin
          if (cc_hit) begin
            cc_q      <= '0;
            maint_req <= 1'b0;
            mon_level <= '0;
          end else begin
            cc_q <= cc_q + STEP_W'(1);
          end
        end
      end
    end
  end

  assert_trend_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (log_req && log_tag.reason == R_CE_TREND) |=> (maint_req && mon_level != 2'd0));
endmodule

// File: rtl/hv_ue_escal.sv
module hv_ue_escal
  import hv_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              wnd_end,
  input  logic [STEP_W-1:0] clean_m,
  output tier_e             tier,
  output logic              log_req,
  output hv_tag_t           log_tag
);
  logic [STEP_W-1:0] cc_q;
  logic              seen_q, cc_hit, clean_wnd;
  tier_e             up;

  assign cc_hit    = ((STEP_W+1)'(cc_q) + (STEP_W+1)'(1)) >= (STEP_W+1)'(clean_m);
  assign clean_wnd = wnd_end && !seen_q && !strobe && (tier != T_NORMAL);

  always_comb begin
    case (tier)
      T_NORMAL:  up = T_ISOLATE;
      T_ISOLATE: up = T_RECOVER;
      default:   up = T_SWITCH;
    endcase
  end

  always_comb begin
    log_req = 1'b0;
    log_tag = '{src: S_UE, reason: R_UE_EVENT, tier: up};
    if (strobe) begin
      log_req = 1'b1;
    end else if (clean_wnd && cc_hit) begin
      log_req = 1'b1;
      log_tag = '{src: S_UE, reason: R_CLEAR, tier: T_NORMAL};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tier   <= T_NORMAL;
      cc_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= wnd_end ? 1'b0 : (seen_q | strobe);
      if (strobe) begin
        tier <= up;
        cc_q <= '0;
      end else if (clean_wnd) begin
        if (cc_hit) begin
          tier <= T_NORMAL;
          cc_q <= '0;
        end else begin
          cc_q <= cc_q + STEP_W'(1);
        end
      end else if (wnd_end) begin
        cc_q <= '0;
      end
    end
  end

  assert_ue_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (tier >= T_ISOLATE));
endmodule

// File: rtl/hv_evidence_fifo.sv
module hv_evidence_fifo
  import hv_pkg::*;
#(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NPUSH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPUSH-1:0] push,
  input  hv_tag_t          tag_in [NPUSH],
  input  logic [TS_W-1:0]  stamp,
  output logic             valid,
  input  logic             ready,
  output logic [TS_W-1:0]  out_stamp,
  output hv_tag_t          out_tag
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned EW = TS_W + TAG_W;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count, free, run;
  logic [NPUSH-1:0] accept;
  logic [AW-1:0] slot [NPUSH];
  logic          pop;

  assign valid = count != '0;
  assign pop   = valid && ready;
  assign free  = DEPTH_V - count;
  assign {out_stamp, out_tag} = mem[rd_ptr];

  always_comb begin
    run = '0;
    for (int i = 0; i < NPUSH; i++) begin
      accept[i] = push[i] && (run < free);
      slot[i]   = wr_ptr + run[AW-1:0];
      if (accept[i]) run = run + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPUSH; i++) begin
      if (accept[i]) mem[slot[i]] <= {stamp, tag_in[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + run[AW-1:0];
      rd_ptr <= rd_ptr + AW'(pop);
      count  <= count + run - (AW+1)'(pop);
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(out_stamp) && $stable(out_tag)));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_V);
endmodule

// File: rtl/health_escalator.sv
module health_escalator
  import hv_pkg::*;
#(
  parameter int unsigned TS_W       = 32,
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned STEP_W     = 4,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_retrain,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic              ev_therm,
  input  logic [WIN_W-1:0]  cfg_window,
  input  logic [CNT_W-1:0]  cfg_thr_retrain,
  input  logic [CNT_W-1:0]  cfg_thr_ce,
  input  logic [CNT_W-1:0]  cfg_thr_therm,
  input  logic [STEP_W-1:0] cfg_persist,
  input  logic [STEP_W-1:0] cfg_clean,
  output logic [2:0]        act_tier,
  output logic [1:0]        mon_level,
  output logic              maint_req,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [TS_W-1:0]   ev_stamp,
  output logic [1:0]        ev_src,
  output logic [2:0]        ev_reason,
  output logic [2:0]        ev_tier
);
  localparam int unsigned NSRC = 4;
  localparam int unsigned NRATE = 2;

  logic [WIN_W-1:0] wcnt;
  logic [TS_W-1:0]  ts;
  logic             wnd_end;

  assign wnd_end = ((WIN_W+1)'(wcnt) + (WIN_W+1)'(1)) >= (WIN_W+1)'(cfg_window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      ts   <= '0;
    end else begin
      wcnt <= wnd_end ? '0 : wcnt + WIN_W'(1);
      ts   <= ts + TS_W'(1);
    end
  end

  logic [NRATE-1:0] rate_strobe;
  logic [CNT_W-1:0] rate_thr [NRATE];
  tier_e            rate_tier [NRATE];
  logic             rate_log [NRATE];
  hv_tag_t          rate_tag [NRATE];

  assign rate_strobe = {ev_therm, ev_retrain};
  assign rate_thr[0] = cfg_thr_retrain;
  assign rate_thr[1] = cfg_thr_therm;

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    hv_rate_engine #(
      .CNT_W   (CNT_W),
      .STEP_W  (STEP_W),
      .THERMAL (g == 1),
      .SRC     ((g == 1) ? S_THERM : S_RETRAIN)
    ) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (rate_strobe[g]),
      .wnd_end   (wnd_end),
      .thr       (rate_thr[g]),
      .persist_n (cfg_persist),
      .clean_m   (cfg_clean),
      .tier      (rate_tier[g]),
      .log_req   (rate_log[g]),
      .log_tag   (rate_tag[g])
    );
  end

  logic    ce_log, ue_log;
  hv_tag_t ce_tag, ue_tag;
  tier_e   ue_tier;

  hv_ce_trend #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ce (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (ev_ce),
    .wnd_end   (wnd_end),
    .thr       (cfg_thr_ce),
    .clean_m   (cfg_clean),
    .mon_level (mon_level),
    .maint_req (maint_req),
    .log_req   (ce_log),
    .log_tag   (ce_tag)
  );

  hv_ue_escal #(.STEP_W(STEP_W)) u_ue (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (ev_ue),
    .wnd_end (wnd_end),
    .clean_m (cfg_clean),
    .tier    (ue_tier),
    .log_req (ue_log),
    .log_tag (ue_tag)
  );

  logic [NSRC-1:0] push;
  hv_tag_t         push_tag [NSRC];
  hv_tag_t         head_tag;

  assign push        = {rate_log[1], ue_log, ce_log, rate_log[0]};
  assign push_tag[0] = rate_tag[0];
  assign push_tag[1] = ce_tag;
  assign push_tag[2] = ue_tag;
  assign push_tag[3] = rate_tag[1];

  hv_evidence_fifo #(.TS_W(TS_W), .DEPTH(FIFO_DEPTH), .NPUSH(NSRC)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .tag_in    (push_tag),
    .stamp     (ts),
    .valid     (ev_valid),
    .ready     (ev_ready),
    .out_stamp (ev_stamp),
    .out_tag   (head_tag)
  );

  assign ev_src    = head_tag.src;
  assign ev_reason = head_tag.reason;
  assign ev_tier   = head_tag.tier;
  assign act_tier  = tier_max(tier_max(rate_tier[0], rate_tier[1]), ue_tier);

  assert_ue_to_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ue |=> (act_tier >= 3'd2));
  assert_ce_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ce && !ev_ue && !ev_retrain && !ev_therm && !wnd_end) |=> $stable(act_tier));
endmodule

// File: tb/tb_health_escalator.sv
`timescale 1ns/1ps
module tb_health_escalator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_retrain = 1'b0, ev_ce = 1'b0, ev_ue = 1'b0, ev_therm = 1'b0;
  logic ev_ready = 1'b1;
  logic [2:0]  act_tier;
  logic [1:0]  mon_level;
  logic        maint_req, ev_valid;
  logic [31:0] ev_stamp;
  logic [1:0]  ev_src;
  logic [2:0]  ev_reason, ev_tier;

  always #2.5 clk = ~clk;

  health_escalator dut (
    .clk(clk), .rst_n(rst_n),
    .ev_retrain(ev_retrain), .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_therm(ev_therm),
    .cfg_window(16'd16), .cfg_thr_retrain(8'd3), .cfg_thr_ce(8'd2), .cfg_thr_therm(8'd2),
    .cfg_persist(4'd2), .cfg_clean(4'd3),
    .act_tier(act_tier), .mon_level(mon_level), .maint_req(maint_req),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_stamp(ev_stamp),
    .ev_src(ev_src), .ev_reason(ev_reason), .ev_tier(ev_tier)
  );

  typedef struct {
    int    stamp;
    int    src;
    int    reason;
    int    tier;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int tests = 0;
  int fails = 0;
  int bts = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) bts <= bts + 1;

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_e(int st, int src, int rs, int tr, string req);
    exp_t e;
    e.stamp = st; e.src = src; e.reason = rs; e.tier = tr; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic at_ts(int t);
    while (bts != t) @(negedge clk);
  endtask

  task automatic strobe(int src, int t);
    at_ts(t);
    case (src)
      0: ev_retrain = 1'b1;
      1: ev_ce = 1'b1;
      2: ev_ue = 1'b1;
      default: ev_therm = 1'b1;
    endcase
    @(negedge clk);
    ev_retrain = 1'b0; ev_ce = 1'b0; ev_ue = 1'b0; ev_therm = 1'b0;
  endtask

  // Scoreboard monitor: one transfer per sampled valid && ready
  always @(negedge clk) begin
    if (rst_n && ev_valid && ev_ready) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected entry: actual stamp %0d src %0d reason %0d tier %0d expected none",
                 ev_stamp, ev_src, ev_reason, ev_tier);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(ev_stamp) != e.stamp || int'(ev_src) != e.src ||
            int'(ev_reason) != e.reason || int'(ev_tier) != e.tier) begin
          fails++;
          $display("FAIL R9 %s entry: actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d", e.req,
                   ev_stamp, ev_src, ev_reason, ev_tier, e.stamp, e.src, e.reason, e.tier);
        end
      end
    end
  end

  initial begin
    // expected evidence stream: stamp, source, reason, tier
    expect_e(15, 0, 0, 1, "R2");
    expect_e(47, 0, 1, 2, "R3");
    expect_e(79, 0, 1, 3, "R3");
    expect_e(127, 0, 2, 0, "R4");
    expect_e(159, 1, 3, 0, "R5");
    expect_e(175, 1, 3, 0, "R5");
    expect_e(223, 1, 2, 0, "R4");
    expect_e(230, 2, 4, 2, "R6");
    expect_e(240, 2, 4, 3, "R6");
    expect_e(303, 2, 2, 0, "R4");
    expect_e(319, 3, 0, 1, "R7");
    expect_e(351, 3, 1, 5, "R7");
    expect_e(399, 3, 2, 0, "R4");
    expect_e(415, 0, 0, 1, "R8");
    expect_e(415, 2, 4, 2, "R8");
    expect_e(415, 3, 0, 1, "R8");
    expect_e(463, 0, 2, 0, "R8");
    expect_e(463, 2, 2, 0, "R8");
    expect_e(463, 3, 2, 0, "R8");

    repeat (3) @(negedge clk);
    check("R1", "act_tier in reset", act_tier, 0);
    check("R1", "ev_valid in reset", ev_valid, 0);
    rst_n = 1'b1;
    check("R1", "act_tier", act_tier, 0);
    check("R1", "mon_level", mon_level, 0);
    check("R1", "maint_req", maint_req, 0);
    check("R1", "ev_valid", ev_valid, 0);

    // retrain ladder
    strobe(0, 2); strobe(0, 5); strobe(0, 15);
    strobe(0, 17);
    check("R2", "act_tier after first over window", act_tier, 1);
    strobe(0, 20); strobe(0, 23);
    strobe(0, 33); strobe(0, 36); strobe(0, 39);
    strobe(0, 49);
    check("R3", "act_tier isolate", act_tier, 2);
    strobe(0, 52); strobe(0, 55);
    strobe(0, 65); strobe(0, 68); strobe(0, 71);
    at_ts(81);
    check("R3", "act_tier recover", act_tier, 3);
    at_ts(128);
    check("R4", "act_tier cleared", act_tier, 0);
    strobe(0, 130); strobe(0, 143);
    at_ts(145);
    check("R2", "act_tier below threshold", act_tier, 0);

    // correctable trend
    strobe(1, 146); strobe(1, 159);
    at_ts(162);
    check("R5", "mon_level", mon_level, 1);
    check("R5", "maint_req", maint_req, 1);
    check("R5", "act_tier", act_tier, 0);
    strobe(1, 165); strobe(1, 170);
    at_ts(178);
    check("R5", "mon_level second", mon_level, 2);
    check("R5", "act_tier second", act_tier, 0);
    at_ts(226);
    check("R4", "mon_level cleared", mon_level, 0);
    check("R4", "maint_req cleared", maint_req, 0);

    // uncorrectable
    strobe(2, 230);
    at_ts(232);
    check("R6", "act_tier isolate", act_tier, 2);
    strobe(2, 240);
    at_ts(242);
    check("R6", "act_tier recover", act_tier, 3);
    at_ts(306);
    check("R4", "act_tier ue cleared", act_tier, 0);

    // thermal
    strobe(3, 308); strobe(3, 312);
    at_ts(322);
    check("R7", "act_tier degrade", act_tier, 1);
    strobe(3, 325); strobe(3, 330);
    strobe(3, 340); strobe(3, 345);
    at_ts(354);
    check("R7", "act_tier safe", act_tier, 5);
    at_ts(402);
    check("R4", "act_tier thermal cleared", act_tier, 0);

    // simultaneous sources under back-pressure
    at_ts(404);
    @(posedge clk); #1 ev_ready = 1'b0;
    strobe(3, 406); strobe(0, 407); strobe(3, 409);
    strobe(0, 410); strobe(0, 413); strobe(2, 415);
    at_ts(418);
    check("R8", "act_tier highest", act_tier, 2);
    check("R10", "ev_valid held", ev_valid, 1);
    check("R10", "ev_stamp held", int'(ev_stamp), 415);
    check("R10", "ev_src held", ev_src, 0);
    at_ts(420);
    @(posedge clk); #1 ev_ready = 1'b1;
    at_ts(470);
    check("R4", "act_tier all cleared", act_tier, 0);
    at_ts(475);
    check("R10", "entries outstanding", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule